// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire serial protocol engine and a nonvolatile byte array. During a write session it gathers the incoming data bytes into a page-sized buffer. Each byte carries a per-lane valid flag. When the session ends with a STOP, the block hands the whole page to the array through one wide masked write. It then holds a busy flag for a fixed number of system clocks, which stands for the internal programming time.

The protocol engine tells the block when a START or repeated START is seen, when a session begins and with which starting address, and when each data byte arrives. It also tells the block when the write-protect pin is strobed and what level the pin had at that point. For every data byte the block answers with a one-cycle accept or refuse pulse. The engine turns that pulse into an ACK or a NoACK on the bus.

The page is selected by the upper address bits, which stay fixed for the whole session. Only the in-page offset advances, and it wraps at the page boundary.

Top module: `pgwr_ctrl`

## Requirements
- R1: A data byte strobe (`byte_vld`) is answered exactly one clock later by a one-cycle pulse on `byte_ack` (accepted) or on `byte_nak` (refused), never on both.
- R2: The first accepted byte lands at in-page offset `sess_addr[3:0]`. Each later accepted byte goes to the next offset, and the offset wraps from 15 back to 0. The page number `sess_addr[ADDR_W-1:4]` stays fixed and is presented on `arr_page`. A byte sent to an offset already filled in the same session replaces the earlier byte.
- R3: The array is written only after STOP. `arr_we` pulses for one clock, one cycle after the `bus_stop` strobe, and carries the whole page in that single pulse. No write happens while bytes are still arriving.
- R4: In `arr_mask`, bit i is set exactly when offset i received a byte in the session. `arr_data[8*i+7:8*i]` holds the latest byte for that offset. Lanes whose mask bit is clear must be left unchanged by the array.
- R5: `busy` rises in the cycle that follows a committing STOP and stays high for exactly `WR_CYCLES` clocks.
- R6: A session that reaches STOP without any accepted byte raises neither `arr_we` nor `busy`.
- R7: If the latched protect level is 1 and the page lies in the upper half of the array (page MSB = 1), the first data byte is refused. Every later byte of that session is refused too, and the STOP commits nothing.
- R8: A protect level of 0 has no effect on writes. A protect level of 1 has no effect on lower-half pages.
- R9: The protect level is latched only from a `wp_strobe` that arrives before the first accepted byte of a session. A strobe after that byte changes nothing.
- R10: A START (`bus_start`) received before STOP discards the buffered bytes, so a STOP that follows writes nothing.
- R11: While `busy` is high, `sess_begin` is ignored. Data bytes are refused and nothing is buffered.
- R12: After reset, `busy`, `arr_we`, `byte_ack` and `byte_nak` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | START or repeated START seen (one-cycle strobe) |
| bus_stop | input | 1 | STOP seen (one-cycle strobe) |
| sess_begin | input | 1 | Write session opens with the address on `sess_addr` |
| sess_addr | input | ADDR_W | Starting byte address of the session |
| wp_strobe | input | 1 | Protect pin sample point reached |
| wp_pin | input | 1 | Protect pin level at the sample point |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte |
| byte_ack | output | 1 | Byte accepted (one-cycle pulse) |
| byte_nak | output | 1 | Byte refused (one-cycle pulse) |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Masked page write strobe to the array |
| arr_page | output | ADDR_W-log2(PAGE_BYTES) | Page number being written |
| arr_mask | output | PAGE_BYTES | Per-byte write enables |
| arr_data | output | PAGE_BYTES*DATA_W | Page data, lane i at bits 8i+7..8i |

## Verification
The bench builds the block with a 9-bit address and 16-byte pages, which gives 32 pages. Both protected upper-half pages and unprotected lower-half pages can therefore be reached within a few sessions. The write time is cut to 20 clocks, so each busy window can be counted cycle by cycle, and sessions can be started inside a window to probe the refuse path. The bench keeps a reference image of the array and compares it page by page with the image built from the `arr_we` pulses. This covers offset wrap, overwrite within one session, and lanes left untouched by the mask.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_LOAD = 2'd1,
      SS_REJ  = 2'd2
   } sess_st_t;
endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8,
   parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         wr_en,
   input  logic [OFF_W-1:0]             wr_off,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [PAGE_BYTES*DATA_W-1:0] page_data,
   output logic [PAGE_BYTES-1:0]        page_mask
);
   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
      logic [DATA_W-1:0] lane_q;
      logic              vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr) begin
            vld_q  <= 1'b0;
         end else if (wr_en && (wr_off == OFF_W'(i))) begin
            lane_q <= wr_data;
            vld_q  <= 1'b1;
         end
      end
      assign page_data[i*DATA_W +: DATA_W] = lane_q;
      assign page_mask[i]                  = vld_q;
   end
endmodule

// File: rtl/pgwr_guard.sv
module pgwr_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic arm,
   input  logic wp_strobe,
   input  logic wp_pin,
   input  logic upper,
   output logic refuse
);
   logic wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wp_q <= 1'b0;
      else if (clr)              wp_q <= 1'b0;
      else if (arm && wp_strobe) wp_q <= wp_pin;
   end

   assign refuse = wp_q && upper;

   // R9
   wp_latch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(arm) && !$past(clr)) |-> $stable(wp_q));
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int WR_CYCLES = 625000,
   parameter int CNT_W     = $clog2(WR_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(WR_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;

   // R5
   busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start));
   // R5
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_q);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int ADDR_W     = 9,
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8,
   parameter int WR_CYCLES  = 625000
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  bus_start,
   input  logic                                  bus_stop,
   input  logic                                  sess_begin,
   input  logic [ADDR_W-1:0]                     sess_addr,
   input  logic                                  wp_strobe,
   input  logic                                  wp_pin,
   input  logic                                  byte_vld,
   input  logic [DATA_W-1:0]                     byte_data,
   output logic                                  byte_ack,
   output logic                                  byte_nak,
   output logic                                  busy,
   output logic                                  arr_we,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  arr_page,
   output logic [PAGE_BYTES-1:0]                 arr_mask,
   output logic [PAGE_BYTES*DATA_W-1:0]          arr_data
);
   import pgwr_pkg::*;

   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;

   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PAGE_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end
   if (WR_CYCLES < 1) begin : g_bad_time
      $error("WR_CYCLES must be at least 1");
   end

   sess_st_t          st_q;
   logic [OFF_W-1:0]  off_q;
   logic [PAGE_W-1:0] page_q;
   logic              first_q;
   logic              ack_q, nak_q, we_q;

   logic sess_ok, clr, refuse, take, rej_now, commit;

   assign sess_ok = sess_begin && !busy;
   assign clr     = bus_start || sess_ok;
   assign take    = byte_vld && (st_q == SS_LOAD) && !(first_q && refuse);
   assign rej_now = byte_vld && (st_q == SS_LOAD) && first_q && refuse;
   assign commit  = bus_stop && (st_q == SS_LOAD) && (arr_mask != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SS_IDLE;
         off_q   <= '0;
         page_q  <= '0;
         first_q <= 1'b0;
         ack_q   <= 1'b0;
         nak_q   <= 1'b0;
         we_q    <= 1'b0;
      end else begin
         ack_q <= take;
         nak_q <= byte_vld && !take;
         we_q  <= commit;
         if (sess_ok) begin
            st_q    <= SS_LOAD;
            off_q   <= sess_addr[OFF_W-1:0];
            page_q  <= sess_addr[ADDR_W-1:OFF_W];
            first_q <= 1'b1;
         end else begin
            if (bus_start || bus_stop) st_q <= SS_IDLE;
            else if (rej_now)          st_q <= SS_REJ;
            if (take) begin
               off_q   <= off_q + 1'b1;
               first_q <= 1'b0;
            end
         end
      end
   end

   pgwr_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .DATA_W     (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .wr_en     (take),
      .wr_off    (off_q),
      .wr_data   (byte_data),
      .page_data (arr_data),
      .page_mask (arr_mask)
   );

   pgwr_guard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .arm       ((st_q == SS_LOAD) && first_q),
      .wp_strobe (wp_strobe),
      .wp_pin    (wp_pin),
      .upper     (page_q[PAGE_W-1]),
      .refuse    (refuse)
   );

   pgwr_timer #(
      .WR_CYCLES (WR_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .busy  (busy)
   );

   assign byte_ack = ack_q;
   assign byte_nak = nak_q;
   assign arr_we   = we_q;
   assign arr_page = page_q;

   // R1
   ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ack || byte_nak) |-> $past(byte_vld));
   // R1
   ack_nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_ack && byte_nak));
   // R2
   page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SS_LOAD) && $past(st_q == SS_LOAD)) |-> $stable(page_q));
   // R3
   we_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> $past(bus_stop));
   // R4
   we_mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (arr_mask != '0));
   // R5
   we_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   // R11
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $past(byte_vld)) |-> !byte_ack);
endmodule

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb;
   localparam int ADDR_W = 9;
   localparam int PB     = 16;
   localparam int DW     = 8;
   localparam int WR     = 20;
   localparam int PW     = ADDR_W - 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_start = 0, bus_stop = 0, sess_begin = 0, wp_strobe = 0, wp_pin = 0, byte_vld = 0;
   logic [ADDR_W-1:0] sess_addr = '0;
   logic [DW-1:0]     byte_data = '0;
   logic byte_ack, byte_nak, busy, arr_we;
   logic [PW-1:0]      arr_page;
   logic [PB-1:0]      arr_mask;
   logic [PB*DW-1:0]   arr_data;

   int n_run = 0, n_fail = 0, we_cnt = 0;
   logic [7:0] act_mem [1<<ADDR_W];
   logic [7:0] exp_mem [1<<ADDR_W];
   logic [PB-1:0] last_mask = '0;
   logic [PW-1:0] last_page = '0;

   always #4 clk = ~clk;

   pgwr_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .DATA_W(DW), .WR_CYCLES(WR)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .sess_begin(sess_begin), .sess_addr(sess_addr), .wp_strobe(wp_strobe),
      .wp_pin(wp_pin), .byte_vld(byte_vld), .byte_data(byte_data),
      .byte_ack(byte_ack), .byte_nak(byte_nak), .busy(busy), .arr_we(arr_we),
      .arr_page(arr_page), .arr_mask(arr_mask), .arr_data(arr_data));

   // array model fed by the write port
   always @(posedge clk) begin
      if (arr_we) begin
         we_cnt <= we_cnt + 1;
         last_mask <= arr_mask;
         last_page <= arr_page;
         for (int i = 0; i < PB; i++)
            if (arr_mask[i]) act_mem[{arr_page, 4'(i)}] <= arr_data[i*8 +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) bus_start = 1;
      @(negedge clk) bus_start = 0;
   endtask

   task automatic open_sess(input logic [ADDR_W-1:0] a);
      pulse_start();
      @(negedge clk) begin sess_begin = 1; sess_addr = a; end
      @(negedge clk) sess_begin = 0;
   endtask

   task automatic strobe_wp(input logic lvl);
      @(negedge clk) begin wp_strobe = 1; wp_pin = lvl; end
      @(negedge clk) wp_strobe = 0;
   endtask

   task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
      @(negedge clk) begin byte_vld = 1; byte_data = d; end
      @(negedge clk) byte_vld = 0;
      chk(byte_ack == exp_ack && byte_nak == !exp_ack, req, {byte_ack, byte_nak}, {exp_ack, !exp_ack});
   endtask

   task automatic stop_sess(input bit exp_we, input string req);
      int n;
      @(negedge clk) bus_stop = 1;
      @(negedge clk) bus_stop = 0;
      chk(arr_we == exp_we, req, arr_we, exp_we);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == (exp_we ? WR : 0), "R5 busy length", n, exp_we ? WR : 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic cmp_page(input logic [PW-1:0] p, input string req);
      int bad = 0;
      for (int i = 0; i < PB; i++)
         if (act_mem[{p, 4'(i)}] !== exp_mem[{p, 4'(i)}]) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   // {addr[8:0], count[4:0], wp, seed[7:0]}
   localparam logic [22:0] VEC [8] = '{
      {9'h005, 5'd3,  1'b0, 8'h10},
      {9'h10E, 5'd5,  1'b0, 8'h20},
      {9'h120, 5'd16, 1'b0, 8'h30},
      {9'h033, 5'd20, 1'b0, 8'h50},
      {9'h150, 5'd4,  1'b1, 8'h70},
      {9'h060, 5'd4,  1'b1, 8'h80},
      {9'h1F0, 5'd1,  1'b0, 8'h90},
      {9'h0F8, 5'd0,  1'b0, 8'hA0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << ADDR_W); i++) begin act_mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
      repeat (3) @(negedge clk);
      chk(!busy && !arr_we && !byte_ack && !byte_nak, "R12 reset", {busy, arr_we, byte_ack, byte_nak}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         logic [ADDR_W-1:0] a;
         int cnt, we0;
         logic wp, rej, com;
         logic [7:0] seed;
         logic [3:0] off;
         logic [PB-1:0] emask;
         a = VEC[v][22:14]; cnt = int'(VEC[v][13:9]); wp = VEC[v][8]; seed = VEC[v][7:0];
         rej = wp && a[8];
         com = (cnt > 0) && !rej;
         off = a[3:0]; emask = '0;
         open_sess(a);
         strobe_wp(wp);
         we0 = we_cnt;
         for (int b = 0; b < cnt; b++) begin
            send_byte(seed + 8'(b), !rej, rej ? "R7 refuse" : (wp ? "R8 lower half" : "R1 accept"));
            if (!rej) begin
               exp_mem[{a[8:4], off}] = seed + 8'(b);
               emask[off] = 1'b1;
               off++;
            end
         end
         chk(we_cnt == we0, "R3 no write before stop", we_cnt, we0);
         stop_sess(com, com ? "R3 commit" : (rej ? "R7 no commit" : "R6 empty"));
         chk(we_cnt == we0 + (com ? 1 : 0), "R3 single write", we_cnt, we0 + (com ? 1 : 0));
         if (com) begin
            chk(last_mask == emask, "R4 mask", last_mask, emask);
            chk(last_page == a[8:4], "R2 page", last_page, a[8:4]);
         end
         cmp_page(a[8:4], "R2 R4 page content");
      end

      // R9: protect strobe after first byte is ignored
      open_sess(9'h180);
      strobe_wp(1'b0);
      send_byte(8'hC1, 1'b1, "R9 first byte");
      exp_mem[9'h180] = 8'hC1;
      strobe_wp(1'b1);
      send_byte(8'hC2, 1'b1, "R9 late strobe ignored");
      exp_mem[9'h181] = 8'hC2;
      stop_sess(1'b1, "R9 commit");
      cmp_page(5'h18, "R9 page content");

      // R10: START before STOP discards the buffer
      open_sess(9'h0C0);
      send_byte(8'hD1, 1'b1, "R10 byte");
      send_byte(8'hD2, 1'b1, "R10 byte");
      pulse_start();
      stop_sess(1'b0, "R10 no commit");
      cmp_page(5'h0C, "R10 page untouched");

      // R11: new session during busy is ignored
      open_sess(9'h090);
      send_byte(8'hE1, 1'b1, "R11 setup byte");
      exp_mem[9'h090] = 8'hE1;
      @(negedge clk) bus_stop = 1;
      @(negedge clk) bus_stop = 0;
      chk(busy == 1'b1, "R5 busy after stop", busy, 1);
      open_sess(9'h0A0);
      send_byte(8'hE2, 1'b0, "R11 byte refused while busy");
      while (busy) @(negedge clk);
      stop_sess(1'b0, "R11 no commit");
      cmp_page(5'h0A, "R11 page untouched");
      cmp_page(5'h09, "R11 earlier page written");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule